// File: doc/BRIEF.md
# Broadcast Interrupt Collector with Polled Service-Request Register

This block receives interrupt events as 32-bit writes on a simple register bus and keeps them as sticky pending bits, one bit for each interrupt group. A write is taken when its node address is either this node's own ID or the all-ones broadcast address. It is never refused or stalled, so any number of interrupt writes can arrive back to back. A consumer, such as an interrupt dispatcher, sees the pending groups on a port and retires them with an acknowledge mask.

The second register holds service-request bits for the units attached to the node. A unit pulses its request input before it signals an interrupt. Software finds the node that is interrupting by ANDing this register with a mask and testing the result for nonzero. It then clears the bits it has handled by writing their pattern to the register. When a set and a clear of the same bit fall in the same cycle, the set wins, so no event is lost.

Top module: `irq_poll_unit`

## Requirements
- R1: An accepted bus write to word offset 0 sets every pending-group bit whose data bit is 1. Pending-group bit k is data bit k. The change shows on `cons_pend` in the cycle after the write.
- R2: A bus write is accepted only when `bus_node` equals `my_node_id` or equals all ones (63). A write with any other node address changes no state.
- R3: Interrupt writes are accepted in every cycle without refusal. Repeated writes OR into the pending bits, and a bit stays 1 however often it is written, until it is cleared.
- R4: A 1 in `cons_ack` clears that pending bit at the next edge. If the same bit is also set by an accepted write in that cycle, it stays 1.
- R5: A 1 on `unit_req[i]` sets service-request bit i. This bit is status register bit 16+i, and it sets at the next edge.
- R6: An accepted bus write to word offset 1 clears exactly those service-request bits whose data bits [31:16] are 1. A request in the same cycle wins over the clear. Status bits [15:0] always read as 0.
- R7: `poll_hit` is 1 exactly when the status register ANDed with `poll_mask` is nonzero.
- R8: A read with `bus_node` equal to `my_node_id` is answered in the next cycle with `bus_rvalid` = 1. Offset 0 returns the pending bits, offset 1 returns the status register, and any other offset returns 0. A read with any other node address gives no `bus_rvalid`. `bus_rdata` holds its value between answers.
- R9: Reset clears all pending-group bits, all service-request bits, `bus_rvalid` and `bus_rdata`.
- R10: A write to any offset other than 0 or 1 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_node_id | input | 6 | This node's bus ID |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Word offset |
| bus_node | input | 6 | Target node address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read answer valid |
| cons_pend | output | 32 | Pending interrupt groups |
| cons_ack | input | 32 | Clear mask for pending groups |
| unit_req | input | 16 | Service-request set pulses |
| poll_mask | input | 32 | Mask for the poll test |
| poll_hit | output | 1 | Masked status is nonzero |

## Verification
The hardest situation to reach from the ports is a set and a clear of the same bit in one cycle. Two cases need it: an interrupt write that meets an acknowledge of the same group, and a unit request that meets a software clear of the same bit. Directed steps build both collisions explicitly. The random phase then drives writes, acknowledges and requests in the same cycles with overlapping dense bit patterns, so these collisions recur many times. It also spreads node addresses over the own ID, the broadcast value and others.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int unsigned QUAD_W = 32;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_IRQ  = 2'd1,
    SEL_STAT = 2'd2
  } rsel_e;
endpackage

// File: rtl/irqp_decode.sv
module irqp_decode
  import irqp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NODE_W   = 6,
  parameter int unsigned IRQ_OFS  = 0,
  parameter int unsigned STAT_OFS = 1
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NODE_W-1:0] node,
  input  logic [NODE_W-1:0] self_id,
  output logic              wr_irq,
  output logic              wr_stat,
  output logic              rd_acc,
  output rsel_e             rd_sel
);
  localparam logic [NODE_W-1:0] BCAST = {NODE_W{1'b1}};

  logic own_hit;
  logic node_ok;

  always_comb begin
    own_hit = (node == self_id);
    node_ok = own_hit || (node == BCAST);
    wr_irq  = wr && node_ok && (addr == ADDR_W'(IRQ_OFS));
    wr_stat = wr && node_ok && (addr == ADDR_W'(STAT_OFS));
    rd_acc  = rd && own_hit;
    if (addr == ADDR_W'(IRQ_OFS))       rd_sel = SEL_IRQ;
    else if (addr == ADDR_W'(STAT_OFS)) rd_sel = SEL_STAT;
    else                                rd_sel = SEL_NONE;
  end
endmodule

// File: rtl/irqp_sticky.sv
module irqp_sticky #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  // set takes priority over clear bit by bit
  always_comb begin
    q_en  = (|set_v) || (|clr_v);
    q_nxt = (q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/irqp_rdport.sv
module irqp_rdport
  import irqp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  rsel_e             rd_sel,
  input  logic [DATA_W-1:0] irq_word,
  input  logic [DATA_W-1:0] stat_word,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] rdata_nxt;

  always_comb begin
    unique case (rd_sel)
      SEL_IRQ:  rdata_nxt = irq_word;
      SEL_STAT: rdata_nxt = stat_word;
      default:  rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_acc) rdata <= rdata_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_acc;
  end
endmodule

// File: rtl/irq_poll_unit.sv
module irq_poll_unit
  import irqp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NODE_W   = 6,
  parameter int unsigned GROUPS   = 32,
  parameter int unsigned UNITS    = 16,
  parameter int unsigned IRQ_OFS  = 0,
  parameter int unsigned STAT_OFS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] my_node_id,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NODE_W-1:0] bus_node,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [GROUPS-1:0] cons_pend,
  input  logic [GROUPS-1:0] cons_ack,
  input  logic [UNITS-1:0]  unit_req,
  input  logic [31:0]       poll_mask,
  output logic              poll_hit
);
  localparam int unsigned DATA_W   = QUAD_W;
  localparam int unsigned UNIT_LSB = DATA_W - UNITS;

  logic              wr_irq;
  logic              wr_stat;
  logic              rd_acc;
  rsel_e             rd_sel;
  logic [GROUPS-1:0] irq_set;
  logic [UNITS-1:0]  stat_clr;
  logic [GROUPS-1:0] irq_q;
  logic [UNITS-1:0]  unit_q;
  logic [DATA_W-1:0] irq_word;
  logic [DATA_W-1:0] stat_word;

  irqp_decode #(
    .ADDR_W(ADDR_W), .NODE_W(NODE_W), .IRQ_OFS(IRQ_OFS), .STAT_OFS(STAT_OFS)
  ) u_dec (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .node(bus_node),
    .self_id(my_node_id), .wr_irq(wr_irq), .wr_stat(wr_stat),
    .rd_acc(rd_acc), .rd_sel(rd_sel)
  );

  always_comb begin
    irq_set  = wr_irq  ? bus_wdata[GROUPS-1:0] : '0;
    stat_clr = wr_stat ? bus_wdata[DATA_W-1:UNIT_LSB] : '0;
  end

  irqp_sticky #(.W(GROUPS)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_v(irq_set), .clr_v(cons_ack), .q(irq_q)
  );

  irqp_sticky #(.W(UNITS)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_v(unit_req), .clr_v(stat_clr), .q(unit_q)
  );

  generate
    if (GROUPS < DATA_W) begin : g_irq_pad
      assign irq_word = {{(DATA_W-GROUPS){1'b0}}, irq_q};
    end else begin : g_irq_full
      assign irq_word = irq_q;
    end
    if (UNIT_LSB > 0) begin : g_stat_pad
      assign stat_word = {unit_q, {UNIT_LSB{1'b0}}};
    end else begin : g_stat_full
      assign stat_word = unit_q;
    end
  endgenerate

  irqp_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .rd_sel(rd_sel),
    .irq_word(irq_word), .stat_word(stat_word),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  assign cons_pend = irq_q;
  assign poll_hit  = |(stat_word & poll_mask);
endmodule

// File: rtl/irqp_chk.sv
module irqp_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NODE_W   = 6,
  parameter int unsigned GROUPS   = 32,
  parameter int unsigned UNITS    = 16,
  parameter int unsigned IRQ_OFS  = 0,
  parameter int unsigned STAT_OFS = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NODE_W-1:0] my_node_id,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NODE_W-1:0] bus_node,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic [GROUPS-1:0] cons_pend,
  input logic [GROUPS-1:0] cons_ack,
  input logic [UNITS-1:0]  unit_req,
  input logic [UNITS-1:0]  unit_q
);
  logic node_ok;
  logic own_rd;
  assign node_ok = (bus_node == my_node_id) || (bus_node == {NODE_W{1'b1}});
  assign own_rd  = bus_rd && (bus_node == my_node_id);

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && node_ok && bus_addr == ADDR_W'(IRQ_OFS))
    |=> ((cons_pend & $past(bus_wdata[GROUPS-1:0])) == $past(bus_wdata[GROUPS-1:0])));

  p_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !node_ok && cons_ack == '0 && unit_req == '0)
    |=> (cons_pend == $past(cons_pend) && unit_q == $past(unit_q)));

  p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|cons_ack && !(bus_wr && node_ok && bus_addr == ADDR_W'(IRQ_OFS)))
    |=> ((cons_pend & $past(cons_ack)) == '0));

  p_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_req) |=> ((unit_q & $past(unit_req)) == $past(unit_req)));

  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && node_ok && bus_addr == ADDR_W'(STAT_OFS) && unit_req == '0)
    |=> ((unit_q & $past(bus_wdata[31:32-UNITS])) == '0));

  p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    own_rd |=> bus_rvalid);

  p_norvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !own_rd |=> !bus_rvalid);
endmodule

bind irq_poll_unit irqp_chk #(
  .ADDR_W(ADDR_W), .NODE_W(NODE_W), .GROUPS(GROUPS), .UNITS(UNITS),
  .IRQ_OFS(IRQ_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .my_node_id(my_node_id), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_node(bus_node),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .cons_pend(cons_pend),
  .cons_ack(cons_ack), .unit_req(unit_req), .unit_q(unit_q)
);

// File: tb/sim_irq_poll_unit.sv
`timescale 1ns/1ps
module sim_irq_poll_unit;
  localparam logic [5:0] ID = 6'd5;

  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [5:0]  bus_node;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] cons_pend;
  logic [31:0] cons_ack;
  logic [15:0] unit_req;
  logic [31:0] poll_mask;
  logic        poll_hit;

  int unsigned n_run = 0;
  int unsigned n_bad = 0;
  bit          done  = 0;

  logic [31:0] m_pend, m_stat, m_rdata;
  logic        m_rvalid;

  irq_poll_unit u0 (
    .clk(clk), .rst_n(rst_n), .my_node_id(ID), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_node(bus_node), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cons_pend(cons_pend),
    .cons_ack(cons_ack), .unit_req(unit_req), .poll_mask(poll_mask),
    .poll_hit(poll_hit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit node_ok(logic [5:0] n);
    return (n == ID) || (n == 6'h3f);
  endfunction

  task automatic check_all(string tag);
    chk({tag, " pend"}, cons_pend, m_pend);
    chk("R7 poll", {31'd0, poll_hit}, {31'd0, |(m_stat & poll_mask)});
    chk("R8 rvalid", {31'd0, bus_rvalid}, {31'd0, m_rvalid});
    chk("R8 rdata", bus_rdata, m_rdata);
  endtask

  // one clock: apply inputs, take the edge, update model, compare
  task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [5:0] n, input logic [31:0] d,
                      input logic [31:0] ack, input logic [15:0] req,
                      input string tag);
    logic [31:0] rd_val;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_node = n; bus_wdata = d;
    cons_ack = ack; unit_req = req;
    @(posedge clk); #1;
    rd_val = (a == 8'd0) ? m_pend : (a == 8'd1) ? m_stat : 32'd0;
    m_rvalid = rd && (n == ID);
    if (m_rvalid) m_rdata = rd_val;
    m_pend = (m_pend & ~ack) | ((wr && node_ok(n) && a == 8'd0) ? d : 32'd0);
    m_stat = (m_stat & ~((wr && node_ok(n) && a == 8'd1) ? (d & 32'hffff0000) : 32'd0))
             | {req, 16'd0};
    bus_wr = 0; bus_rd = 0; cons_ack = '0; unit_req = '0;
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #23;
    m_pend = '0; m_stat = '0; m_rdata = '0; m_rvalid = 1'b0;
    check_all("R9");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1ee7));
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_node = '0; bus_wdata = '0;
    cons_ack = '0; unit_req = '0; poll_mask = '0;
    do_reset();
    @(posedge clk); #1;

    // R1: own ID and broadcast
    step(1, 0, 0, ID, 32'h0000_00f1, 0, 0, "R1 own");
    step(1, 0, 0, 6'h3f, 32'h8000_0000, 0, 0, "R1 bcast");
    // R2: foreign node, also to status offset
    step(1, 0, 0, 6'd9, 32'h0f0f_0000, 0, 0, "R2 foreign");
    // R3: back to back, same bit repeated
    step(1, 0, 0, ID, 32'h0000_0100, 0, 0, "R3 b2b1");
    step(1, 0, 0, ID, 32'h0000_0100, 0, 0, "R3 b2b2");
    step(1, 0, 0, 6'h3f, 32'h0000_0200, 0, 0, "R3 b2b3");
    // R4: ack clears, ack vs same-cycle set
    step(0, 0, 0, ID, 0, 32'h0000_0100, 0, "R4 ack");
    step(1, 0, 0, ID, 32'h0000_0001, 32'h0000_0201, 0, "R4 setwins");
    // R5: unit requests, then poll R7
    poll_mask = 32'h0004_0000;
    step(0, 0, 0, ID, 0, 0, 16'h0005, "R5 req");
    // R6: clear with same-cycle request, lower bits ignored
    step(1, 0, 1, ID, 32'h0005_ffff, 0, 16'h0004, "R6 setwins");
    step(1, 0, 1, 6'd2, 32'h0004_0000, 0, 0, "R2 stat foreign");
    // R10: other offset
    step(1, 0, 8'd7, ID, 32'hffff_ffff, 0, 0, "R10 other");
    // R8: reads
    step(0, 1, 0, ID, 0, 0, 0, "R8 rd irq");
    step(0, 1, 1, ID, 0, 0, 0, "R8 rd stat");
    step(0, 1, 8'd3, ID, 0, 0, 0, "R8 rd other");
    step(0, 1, 0, 6'h3f, 0, 0, 0, "R8 rd bcast");
    step(0, 0, 0, ID, 0, 0, 0, "R8 hold");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] n;
      logic [1:0] k;
      logic [7:0] a;
      logic       w;
      k = 2'($urandom_range(0, 3));
      n = (k == 0) ? ID : (k == 1) ? 6'h3f : 6'($urandom);
      k = 2'($urandom_range(0, 3));
      a = (k == 3) ? 8'($urandom) : {6'd0, k};
      w = 1'($urandom);
      if ((i % 97) == 0) poll_mask = $urandom;
      step(w, !w && ($urandom_range(0, 2) == 0), a, n, $urandom,
           ($urandom_range(0, 1) == 0) ? $urandom : 32'd0,
           ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'd0, "R3 random");
    end

    // R9: reset mid-run after filling state
    step(1, 0, 0, ID, 32'hffff_ffff, 0, 16'hffff, "R1 fill");
    do_reset();
    @(posedge clk); #1;
    step(0, 1, 1, ID, 0, 0, 0, "R9 stat after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule